// File: doc/BRIEF.md
# Three-Level Interrupt Aggregator with Indirect Configuration

This block collects a wide vector of interrupt lines and drives one summary interrupt. The lines are grouped into blocks of eight. Eight blocks make a master, and the masters are summarised in a single root byte. Software walks this tree from the root, through a master status byte, down to one block. It finds which lines are pending by reading only a few bytes.

Access goes through a small byte-wide register window. To reach a block, software first writes its index into a select register. After that it can read the block's latched pending bits or the current raw levels of its eight lines. It can also write a configuration byte that names one line of the block and sets how that line triggers (edge or level, and which polarity) or clears its pending bit. Serial transport of the register accesses and input synchronisation belong outside the block.

Top module: `hier_irq_aggr`

## Requirements
- R1: The window has nine byte registers at fixed offsets from base 0x1BB: root at 0x1BB, master status 0..3 at 0x1BC..0x1BF, select at 0x1C0, latched status at 0x1C1, config at 0x1C2 and real-time status at 0x1C3. The config register and every address outside the window read as zero, and writes to read-only registers have no effect.
- R2: In the root byte, bit 0 always reads 0 and bit m+1 is set when any block of master m has a pending line.
- R3: Bit i of the status byte of master m is the OR of the eight pending bits of block m*8+i. Interrupt n belongs to block n/8, at bit n%8.
- R4: A write to the select register stores the byte, and reading it returns the stored byte. The latched status register returns the pending byte of the selected block. A select value at or above the block count makes the latched and real-time reads return zero and makes config writes have no effect.
- R5: The real-time status register returns the present input levels of the selected block's eight lines, in the same cycle and with no latching.
- R6: A config write takes effect only when bit 7 is 1. Bits 6:4 pick the line within the selected block. When bit 7 is 0, the write changes neither that line's trigger setting nor its pending bit.
- R7: Edge mode is selected with bit 0 = 0. If bit 2 = 0, a rising edge (low in one cycle, high in the next) sets pending. If bit 1 = 0, a falling edge sets pending. Pending is visible from the clock edge that samples the new level.
- R8: Level mode is selected with bit 0 = 1. If bit 2 = 0, pending is set on every cycle the line is high. If bit 1 = 0, pending is set on every cycle the line is low.
- R9: When bits 1 and 2 are both 1, the line never becomes pending. After reset every line is in edge mode with both masks set.
- R10: A config write with bit 3 = 1 clears the chosen line's pending bit at that clock edge, even if a trigger event occurs in the same cycle. Otherwise a pending bit stays set until it is cleared.
- R11: The summary output is high exactly when at least one pending bit is set. It follows the pending bits with no extra delay.
- R12: Reset is synchronous and active low. It clears all pending bits and the select register, and drives the summary output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_IRQ | Interrupt lines, already synchronous to clk |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr_en | input | 1 | Write strobe for reg_wdata at reg_addr |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq_out | output | 1 | Summary interrupt |

## Verification
Writes to the select and config registers take effect at the clock edge that samples the write strobe. A trigger seen on an input line shows up as a pending bit at that same edge. The root, master and latched reads and the summary output follow the pending bits combinationally. The real-time read follows the input combinationally. For these reasons the bench drives every input at the falling edge. A behavioural model advances at the rising edge, and both the read data and the summary output are compared at the next falling edge. So every result is checked exactly one edge after the stimulus that caused it. Directed sequences cover same-edge clear against a new event, ignored writes, masked lines and out-of-range selects. These are mixed with seeded random traffic.

// File: rtl/hirq_pkg.sv
// Shared constants and types for the three-level interrupt aggregator.
// Assumes: eight lines per block and eight blocks per master.
package hirq_pkg;
    localparam int LINES_PER_BLK = 8;
    localparam int BLKS_PER_MST  = 8;

    // register offsets from the window base
    localparam int OFS_ROOT  = 0;
    localparam int OFS_MST0  = 1;
    localparam int OFS_SEL   = 5;
    localparam int OFS_LATCH = 6;
    localparam int OFS_CFG   = 7;
    localparam int OFS_RT    = 8;

    // config byte field positions
    localparam int CB_LVL  = 0;
    localparam int CB_MFE  = 1;
    localparam int CB_MRE  = 2;
    localparam int CB_CLR  = 3;
    localparam int CB_WREN = 7;

    typedef struct packed {
        logic lvl;      // 1: level mode, 0: edge mode
        logic mask_fe;  // 1: ignore falling edge / low level
        logic mask_re;  // 1: ignore rising edge / high level
    } trig_cfg_t;
endpackage

// File: rtl/hirq_line.sv
// One interrupt line: trigger setting, previous-sample register and sticky pending bit.
// Assumes: line_in is already synchronous; cfg_we is asserted only for an accepted
// config write addressed to this line.
module hirq_line
    import hirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_in,
    input  logic       cfg_we,
    input  logic [7:0] cfg_byte,
    output logic       pending
);
    trig_cfg_t cfg_q;
    logic      prev_q;
    logic      hit;

    // store the trigger setting on an accepted config write
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '{lvl: 1'b0, mask_fe: 1'b1, mask_re: 1'b1};
        else if (cfg_we)
            cfg_q <= '{lvl: cfg_byte[CB_LVL], mask_fe: cfg_byte[CB_MFE], mask_re: cfg_byte[CB_MRE]};
    end

    // keep last cycle's level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= line_in;
    end

    // trigger event under the current setting
    always_comb begin
        if (cfg_q.lvl)
            hit = (!cfg_q.mask_re && line_in) || (!cfg_q.mask_fe && !line_in);
        else
            hit = (!cfg_q.mask_re && line_in && !prev_q) || (!cfg_q.mask_fe && !line_in && prev_q);
    end

    // sticky pending bit, clear wins over a same-cycle event
    always_ff @(posedge clk) begin
        if (!rst_n)                          pending <= 1'b0;
        else if (cfg_we && cfg_byte[CB_CLR]) pending <= 1'b0;
        else if (hit)                        pending <= 1'b1;
    end
endmodule

// File: rtl/hirq_tree.sv
// OR-reduction tree: pending lines -> block flags -> master flags -> summary output.
// Assumes: NUM_IRQ is a multiple of eight.
module hirq_tree
    import hirq_pkg::*;
#(
    parameter int NUM_IRQ = 256,
    localparam int NUM_BLK = NUM_IRQ / LINES_PER_BLK,
    localparam int NUM_MST = (NUM_BLK + BLKS_PER_MST - 1) / BLKS_PER_MST,
    localparam int PAD_W   = NUM_MST * BLKS_PER_MST
)
(
    input  logic [NUM_IRQ-1:0] pend,
    output logic [PAD_W-1:0]   blk_pad,
    output logic [NUM_MST-1:0] mst_any,
    output logic               irq_out
);
    logic [NUM_BLK-1:0] blk_any;

    // block level: any of eight lines pending
    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
        assign blk_any[b] = |pend[b*LINES_PER_BLK +: LINES_PER_BLK];
    end

    // pad the block flags to whole masters
    assign blk_pad = PAD_W'(blk_any);

    // master level: any of eight blocks flagged
    for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
        assign mst_any[m] = |blk_pad[m*BLKS_PER_MST +: BLKS_PER_MST];
    end

    // summary line
    assign irq_out = |mst_any;
endmodule

// File: rtl/hirq_regs.sv
// Register window: block select, config write strobes and read multiplexer.
// Assumes: at most four masters, fewer than 256 blocks, and reads without side effects.
module hirq_regs
    import hirq_pkg::*;
#(
    parameter int                NUM_IRQ   = 256,
    parameter int                ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h1BB,
    localparam int NUM_BLK = NUM_IRQ / LINES_PER_BLK,
    localparam int NUM_MST = (NUM_BLK + BLKS_PER_MST - 1) / BLKS_PER_MST,
    localparam int PAD_W   = NUM_MST * BLKS_PER_MST,
    localparam int BLK_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
)
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [7:0]         wdata,
    input  logic [NUM_IRQ-1:0] pend,
    input  logic [NUM_IRQ-1:0] lines,
    input  logic [PAD_W-1:0]   blk_pad,
    input  logic [NUM_MST-1:0] mst_any,
    output logic [7:0]         sel_q,
    output logic [NUM_IRQ-1:0] cfg_we_vec,
    output logic [7:0]         rdata
);
    localparam logic [ADDR_W-1:0] A_ROOT  = ADDR_W'(BASE_ADDR + OFS_ROOT);
    localparam logic [ADDR_W-1:0] A_SEL   = ADDR_W'(BASE_ADDR + OFS_SEL);
    localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'(BASE_ADDR + OFS_LATCH);
    localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(BASE_ADDR + OFS_CFG);
    localparam logic [ADDR_W-1:0] A_RT    = ADDR_W'(BASE_ADDR + OFS_RT);
    localparam logic [7:0]        BLK_LIM = 8'(NUM_BLK);

    logic             sel_ok;
    logic [BLK_W-1:0] blk_idx;

    assign sel_ok  = sel_q < BLK_LIM;
    assign blk_idx = sel_q[BLK_W-1:0];

    // block select register
    always_ff @(posedge clk) begin
        if (!rst_n)                       sel_q <= '0;
        else if (wr_en && addr == A_SEL)  sel_q <= wdata;
    end

    // one-hot config strobe for the addressed line of the selected block
    always_comb begin
        cfg_we_vec = '0;
        if (wr_en && addr == A_CFG && wdata[CB_WREN] && sel_ok)
            cfg_we_vec[{blk_idx, wdata[6:4]}] = 1'b1;
    end

    // read data multiplexer, zero for anything unmapped
    always_comb begin
        rdata = '0;
        if (addr == A_ROOT)
            rdata = 8'({mst_any, 1'b0});
        for (int m = 0; m < NUM_MST; m++) begin
            if (addr == ADDR_W'(BASE_ADDR + OFS_MST0 + m))
                rdata = blk_pad[m*BLKS_PER_MST +: BLKS_PER_MST];
        end
        if (addr == A_SEL)
            rdata = sel_q;
        if (addr == A_LATCH && sel_ok)
            rdata = pend[blk_idx*LINES_PER_BLK +: LINES_PER_BLK];
        if (addr == A_RT && sel_ok)
            rdata = lines[blk_idx*LINES_PER_BLK +: LINES_PER_BLK];
    end
endmodule

// File: rtl/hier_irq_aggr.sv
// Top of the three-level interrupt aggregator: per-line cells, OR tree and register window.
// Assumes: irq_in is synchronous to clk and the register port is a simple strobe interface.
module hier_irq_aggr
    import hirq_pkg::*;
#(
    parameter int                NUM_IRQ   = 256,
    parameter int                ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h1BB,
    localparam int NUM_BLK = NUM_IRQ / LINES_PER_BLK,
    localparam int NUM_MST = (NUM_BLK + BLKS_PER_MST - 1) / BLKS_PER_MST,
    localparam int PAD_W   = NUM_MST * BLKS_PER_MST
)
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr_en,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic               irq_out
);
    logic [NUM_IRQ-1:0] pend_vec;
    logic [NUM_IRQ-1:0] cfg_we_vec;
    logic [PAD_W-1:0]   blk_pad;
    logic [NUM_MST-1:0] mst_any;
    logic [7:0]         sel_q;

    // one cell per interrupt line
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        hirq_line u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_in  (irq_in[i]),
            .cfg_we   (cfg_we_vec[i]),
            .cfg_byte (reg_wdata),
            .pending  (pend_vec[i])
        );
    end

    hirq_tree #(.NUM_IRQ(NUM_IRQ)) u_tree (
        .pend    (pend_vec),
        .blk_pad (blk_pad),
        .mst_any (mst_any),
        .irq_out (irq_out)
    );

    hirq_regs #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (reg_addr),
        .wr_en      (reg_wr_en),
        .wdata      (reg_wdata),
        .pend       (pend_vec),
        .lines      (irq_in),
        .blk_pad    (blk_pad),
        .mst_any    (mst_any),
        .sel_q      (sel_q),
        .cfg_we_vec (cfg_we_vec),
        .rdata      (reg_rdata)
    );
endmodule

// File: rtl/hier_irq_aggr_chk.sv
// Assertion checker for hier_irq_aggr, attached by bind below.
// Assumes: it sees the top ports plus the select register and pending vector.
module hier_irq_aggr_chk
    import hirq_pkg::*;
#(
    parameter int                NUM_IRQ   = 256,
    parameter int                ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h1BB,
    localparam int NUM_BLK = NUM_IRQ / LINES_PER_BLK,
    localparam int BLK_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1,
    localparam int IDX_W   = BLK_W + 3
)
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_IRQ-1:0] irq_in,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               reg_wr_en,
    input logic [7:0]         reg_wdata,
    input logic [7:0]         reg_rdata,
    input logic               irq_out,
    input logic [7:0]         sel_q,
    input logic [NUM_IRQ-1:0] pend_vec
);
    localparam logic [ADDR_W-1:0] A_ROOT = ADDR_W'(BASE_ADDR + OFS_ROOT);
    localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(BASE_ADDR + OFS_SEL);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(BASE_ADDR + OFS_CFG);
    localparam logic [ADDR_W-1:0] A_RT   = ADDR_W'(BASE_ADDR + OFS_RT);
    localparam logic [7:0]        BLK_LIM = 8'(NUM_BLK);

    logic [IDX_W-1:0] clr_idx;
    logic [BLK_W-1:0] blk_idx;
    logic             out_of_win;

    assign clr_idx    = {sel_q[BLK_W-1:0], reg_wdata[6:4]};
    assign blk_idx    = sel_q[BLK_W-1:0];
    assign out_of_win = (reg_addr < A_ROOT) || (reg_addr > A_RT) || (reg_addr == A_CFG);

    // R2
    root_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_ROOT) |-> (!reg_rdata[0] && ((|reg_rdata) == irq_out)));

    // R11
    irq_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (pend_vec != '0));

    // R10
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == A_CFG && reg_wdata[CB_WREN] && reg_wdata[CB_CLR] && sel_q < BLK_LIM)
        |=> !pend_vec[$past(clr_idx)]);

    // R5
    rt_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_RT && sel_q < BLK_LIM) |-> (reg_rdata == irq_in[blk_idx*LINES_PER_BLK +: LINES_PER_BLK]));

    // R1
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_win |-> (reg_rdata == 8'h00));

    // R4
    sel_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == A_SEL) |=> (sel_q == $past(reg_wdata)));
endmodule

bind hier_irq_aggr hier_irq_aggr_chk #(
    .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .reg_addr  (reg_addr),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .sel_q     (sel_q),
    .pend_vec  (pend_vec)
);

// File: tb/test_hier_irq_aggr.sv
`timescale 1ns/1ps
module test_hier_irq_aggr;
    localparam int         N    = 256;
    localparam int         NB   = 32;
    localparam logic [9:0] BASE = 10'h1BB;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] irq_in;
    logic [9:0]   reg_addr;
    logic         reg_wr_en;
    logic [7:0]   reg_wdata;
    logic [7:0]   reg_rdata;
    logic         irq_out;

    hier_irq_aggr i_hier_irq_aggr (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    always #2 clk = ~clk;

    // behavioural model state
    logic [N-1:0] m_pend, m_prev, m_lvl, m_mfe, m_mre;
    logic [7:0]   m_sel;
    int    n_chk = 0;
    int    n_fail = 0;
    string ptag = "R4";
    bit    done = 0;

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, reg_addr, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(logic [9:0] a);
        int o;
        logic [7:0] r;
        o = int'(a) - int'(BASE);
        r = 8'h00;
        if (o == 0) begin
            for (int m = 0; m < 4; m++) r[m+1] = |m_pend[m*64 +: 64];
        end else if (o >= 1 && o <= 4) begin
            for (int i = 0; i < 8; i++) r[i] = |m_pend[((o-1)*8 + i)*8 +: 8];
        end else if (o == 5) r = m_sel;
        else if (o == 6 && m_sel < NB) r = m_pend[m_sel*8 +: 8];
        else if (o == 8 && m_sel < NB) r = irq_in[m_sel*8 +: 8];
        return r;
    endfunction

    // advance the model by one rising edge
    task automatic model_clock();
        for (int i = 0; i < N; i++) begin
            logic hit, wr;
            if (m_lvl[i]) hit = (!m_mre[i] && irq_in[i]) || (!m_mfe[i] && !irq_in[i]);
            else hit = (!m_mre[i] && irq_in[i] && !m_prev[i]) || (!m_mfe[i] && !irq_in[i] && m_prev[i]);
            wr = reg_wr_en && reg_addr == BASE + 10'd7 && reg_wdata[7] && m_sel < NB
                 && i == int'(m_sel) * 8 + int'(reg_wdata[6:4]);
            if (wr && reg_wdata[3]) m_pend[i] = 1'b0;
            else if (hit) m_pend[i] = 1'b1;
            if (wr) begin
                m_lvl[i] = reg_wdata[0]; m_mfe[i] = reg_wdata[1]; m_mre[i] = reg_wdata[2];
            end
            m_prev[i] = irq_in[i];
        end
        if (reg_wr_en && reg_addr == BASE + 10'd5) m_sel = reg_wdata;
    endtask

    task automatic check_all();
        int o;
        string tag;
        o = int'(reg_addr) - int'(BASE);
        if (o == 0) tag = "R2";
        else if (o >= 1 && o <= 4) tag = "R3";
        else if (o == 5) tag = "R4";
        else if (o == 6) tag = ptag;
        else if (o == 8) tag = "R5";
        else tag = "R1";
        chk(tag, reg_rdata, exp_read(reg_addr));
        chk("R11", {7'd0, irq_out}, {7'd0, |m_pend});
    endtask

    // drive at the falling edge, model at the rising edge, check at the next falling edge
    task automatic cyc(int o, logic we, logic [7:0] d);
        reg_addr = 10'(int'(BASE) + o); reg_wr_en = we; reg_wdata = d;
        @(posedge clk);
        model_clock();
        @(negedge clk);
        check_all();
    endtask

    function automatic logic [7:0] cfgb(int idx, bit clr, bit mre, bit mfe, bit lvl);
        return {1'b1, 3'(idx), clr, mre, mfe, lvl};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24601));
        rst_n = 1'b0; irq_in = '0; reg_addr = BASE + 10'd5; reg_wr_en = 1'b0; reg_wdata = '0;
        m_pend = '0; m_prev = '0; m_lvl = '0; m_mfe = '1; m_mre = '1; m_sel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        chk("R12", reg_rdata, 8'h00);
        chk("R12", {7'd0, irq_out}, 8'h00);
        rst_n = 1'b1;

        // R9: default setting never latches
        ptag = "R9";
        cyc(5, 1, 8'd0);
        irq_in[2] = 1'b1; cyc(6, 0, 0);
        irq_in[2] = 1'b0; cyc(6, 0, 0);
        cyc(0, 0, 0);

        // R7: rising edge on line 3 and falling edge on line 4 of block 2
        ptag = "R7";
        cyc(5, 1, 8'd2);
        cyc(7, 1, cfgb(3, 0, 0, 1, 0));
        cyc(7, 1, cfgb(4, 0, 1, 0, 0));
        irq_in[19] = 1'b1; cyc(6, 0, 0);
        irq_in[20] = 1'b1; cyc(6, 0, 0);
        irq_in[20] = 1'b0; cyc(6, 0, 0);
        cyc(1, 0, 0);
        cyc(0, 0, 0);

        // R10: clear of line 3, then same-edge clear against a high level on line 5
        ptag = "R10";
        cyc(7, 1, cfgb(3, 1, 0, 1, 0));
        cyc(6, 0, 0);
        cyc(7, 1, cfgb(5, 0, 0, 1, 1));
        irq_in[21] = 1'b1; cyc(6, 0, 0);
        cyc(7, 1, cfgb(5, 1, 0, 1, 1));
        cyc(6, 0, 0);
        cyc(7, 1, cfgb(5, 1, 1, 1, 1));
        cyc(6, 0, 0);
        cyc(6, 0, 0);

        // R8: active-low level on line 6
        ptag = "R8";
        cyc(7, 1, cfgb(6, 0, 1, 0, 1));
        cyc(6, 0, 0);
        irq_in[22] = 1'b1;
        cyc(7, 1, cfgb(6, 1, 1, 0, 1));
        cyc(6, 0, 0);
        irq_in[22] = 1'b0; cyc(6, 0, 0);

        // R6: writes with bit 7 low neither unmask nor clear
        ptag = "R6";
        cyc(7, 1, 8'h70);
        irq_in[23] = 1'b1; cyc(6, 0, 0);
        irq_in[23] = 1'b0; cyc(6, 0, 0);
        irq_in[19] = 1'b0; cyc(6, 0, 0);
        irq_in[19] = 1'b1; cyc(6, 0, 0);
        cyc(7, 1, 8'h38);
        cyc(6, 0, 0);

        // R4: out-of-range select
        ptag = "R4";
        cyc(5, 1, 8'd40);
        cyc(6, 0, 0);
        cyc(8, 0, 0);
        cyc(7, 1, cfgb(0, 0, 0, 0, 1));
        cyc(5, 1, 8'd0);
        cyc(6, 0, 0);

        // seeded random traffic, R1..R5 and R11 checked every cycle
        for (int k = 0; k < 6000; k++) begin
            int op;
            if ($urandom % 2 == 0) irq_in[$urandom % N] ^= 1'b1;
            op = int'($urandom % 10);
            if (op < 3)
                cyc(7, 1, {($urandom % 8) != 0, 3'($urandom), 4'($urandom)});
            else if (op == 3)
                cyc(5, 1, 8'($urandom % 36));
            else if (op == 4)
                cyc(int'($urandom % 64) - 20, 0, 8'($urandom));
            else
                cyc(int'($urandom % 10), $urandom % 4 == 0, 8'($urandom));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule